// File: doc/BRIEF.md
# Counter-Driven Fibonacci Term Generator

This block produces the opening terms of the Fibonacci series, one term per clock. A free-running binary counter provides the position in the series, and a purely combinational decoder turns each counter state into the term for that position. With the default configuration the counter is 3 bits wide and the output is 4 bits, so the output runs 0, 1, 1, 2, 3, 5, 8, 13 and then starts again at 0. No adder or history registers sit in the path that produces the terms.

Every counter code lies on the single main cycle. The generator therefore needs no special start-up state and always settles into the series, whatever state it powers up in. A synchronous clear returns the counter to its first position. The clear wins over counting when both apply. The counter and output widths are parameters, and an elaboration check rejects any width pair where the last term would not fit. A second parameter chooses whether the decoder is built as a constant lookup table or as an evaluated function.

Top module: `fib_seq_gen`

## Requirements
- R1: `term` is an unsigned binary value, 4 bits wide by default. While `clr` is low, it steps through 0, 1, 1, 2, 3, 5, 8, 13 at one term per rising clock edge.
- R2: From the third position of each period onward, every term equals the sum of the two terms just before it.
- R3: When `clr` is high at a rising edge, `term` is 0 after that edge, whatever position the series was at.
- R4: The clear has priority over counting: while `clr` stays high across several edges, `term` stays at 0.
- R5: After the term 13, the next edge gives 0 and the series repeats with a period of 8 clocks. No counter state is left off this cycle.
- R6: `term` changes only just after a rising clock edge and holds its value for the rest of the clock period.
- R7: After `clr` falls, the first edge with `clr` low gives the term 1. From there the series continues in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to the first position, active high, takes priority over counting |
| term | output | OUT_W (4) | Current term of the series, unsigned binary |

## Verification
The hardest situation to reach is a clear that lands partway through a period: at a position other than 0, and in particular just before the wrap from 13 back to 0. This matters because it must restart the series without skipping or repeating a term. The stimulus runs the generator freely for several full periods. It then raises `clr` at the fourth position and again at the last position. It checks that `term` reads 0 and then resumes at 1, 1, 2. The bench also samples twice within each clock period to confirm that the output moves only at edges.

// File: rtl/fib_seq_pkg.sv
package fib_seq_pkg;

   // Term k of the series that starts 0, 1.
   function automatic int unsigned fib_term(input int unsigned k);
      int unsigned a;
      int unsigned b;
      int unsigned t;
      a = 0;
      b = 1;
      for (int unsigned i = 0; i < k; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   // Bits needed to hold a value.
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((v >> n) != 0) n++;
      return n;
   endfunction

endpackage

// File: rtl/fib_seq_counter.sv
module fib_seq_counter #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             clr,
   output logic [CNT_W-1:0] state
);

   logic [CNT_W-1:0] cnt_q;

   // Plain binary count: every code leads to its successor, so all
   // codes lie on one cycle and no lock-up state exists.
   always_ff @(posedge clk) begin
      if (clr) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign state = cnt_q;

   AST_CLEAR_ZERO: assert property (@(posedge clk)
      clr |=> (state == '0));                                  // R3
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (clr)
      1'b1 |=> (state == CNT_W'($past(state) + 1'b1)));        // R5

endmodule

// File: rtl/fib_seq_decoder.sv
module fib_seq_decoder #(
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned OUT_W   = 4,
   parameter bit          USE_ROM = 1'b1
) (
   input  logic [CNT_W-1:0] state,
   output logic [OUT_W-1:0] term
);
   import fib_seq_pkg::*;

   localparam int unsigned STATES = 1 << CNT_W;

   generate
      if (USE_ROM) begin : g_rom
         logic [OUT_W-1:0] rom [STATES];
         for (genvar i = 0; i < STATES; i++) begin : g_entry
            assign rom[i] = OUT_W'(fib_term(i));
         end
         assign term = rom[state];
      end else begin : g_func
         always_comb term = OUT_W'(fib_term(int'(state)));
      end
   endgenerate

   always_comb begin
      if (state < CNT_W'(2))
         AST_HEAD_TERMS: assert (term == OUT_W'(state));       // R1
   end

endmodule

// File: rtl/fib_seq_gen.sv
module fib_seq_gen #(
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned OUT_W   = 4,
   parameter bit          USE_ROM = 1'b1
) (
   input  logic             clk,
   input  logic             clr,
   output logic [OUT_W-1:0] term
);
   import fib_seq_pkg::*;

   localparam int unsigned LAST_TERM = fib_term((1 << CNT_W) - 1);
   localparam int unsigned NEED_W    = bits_for(LAST_TERM);

   generate
      if (CNT_W < 1 || CNT_W > 5) begin : g_bad_cnt
         $error("fib_seq_gen: CNT_W must be 1 to 5");
      end
      if (OUT_W < NEED_W) begin : g_bad_out
         $error("fib_seq_gen: OUT_W too narrow for last term");
      end
   endgenerate

   logic [CNT_W-1:0] state;

   fib_seq_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk  (clk),
      .clr  (clr),
      .state(state)
   );

   fib_seq_decoder #(
      .CNT_W  (CNT_W),
      .OUT_W  (OUT_W),
      .USE_ROM(USE_ROM)
   ) u_dec (
      .state(state),
      .term (term)
   );

   AST_CLEAR_HOLD: assert property (@(posedge clk)
      clr |=> (term == '0));                                   // R4
   AST_FIB_RULE: assert property (@(posedge clk) disable iff (clr)
      (state >= CNT_W'(2)) |-> (term == $past(term) + $past(term, 2))); // R2
   AST_EDGE_ONLY: assert property (@(posedge clk)
      $stable(state) |-> $stable(term));                       // R6

endmodule

// File: tb/fib_seq_gen_test.sv
module fib_seq_gen_test;

   localparam int OUT_W = 4;
   localparam int PERIOD = 8;

   logic             clk = 1'b0;
   logic             clr = 1'b1;
   logic [OUT_W-1:0] term;

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fib_seq_gen #(.CNT_W(3), .OUT_W(OUT_W), .USE_ROM(1'b1)) uut (
      .clk (clk),
      .clr (clr),
      .term(term)
   );

   function automatic int expect_term(input int k);
      int a = 0;
      int b = 1;
      int t;
      for (int i = 0; i < k; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Advance one edge and sample 5 ns later (away from the edge).
   task automatic step;
      @(posedge clk);
      #5;
   endtask

   int idx;
   int p1;
   int p2;

   task automatic run_free(input int n);
      for (int s = 0; s < n; s++) begin
         step();
         idx = (idx + 1) % PERIOD;
         check("R1", int'(term), expect_term(idx));
         if (idx >= 2) check("R2", int'(term), p1 + p2);
         if (idx == 0) check("R5", int'(term), 0);
         #10;
         check("R6", int'(term), expect_term(idx));
         p2 = p1;
         p1 = int'(term);
      end
   endtask

   task automatic clear_at(input int pos);
      while (idx != pos) run_free(1);
      clr = 1'b1;
      step();
      check("R3", int'(term), 0);
      step();
      check("R4", int'(term), 0);
      clr = 1'b0;
      idx = 0;
      step();
      idx = 1;
      check("R7", int'(term), 1);
      p2 = 0;
      p1 = 1;
      run_free(3);
   endtask

   initial begin
      clr = 1'b1;
      step();
      check("R3", int'(term), 0);
      step();
      check("R4", int'(term), 0);
      clr = 1'b0;
      idx = 0;
      p1 = 0;
      p2 = 0;
      run_free(3 * PERIOD);
      clear_at(3);
      clear_at(7);
      run_free(PERIOD);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
      end
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule